// File: doc/BRIEF.md
# Character Display Instruction and Address Unit

This block is the command-processing core of a character-matrix display controller. A host delivers a stream of byte writes, each tagged by a register-select bit. With the bit low, the byte is an instruction. With the bit high, the byte is a character or pattern to store. The unit decodes each instruction and keeps the controller's working state: the address pointer, the horizontal scroll offset of the visible window, the entry, display and font flags, and the extended analog-setting registers. Every stored byte leaves through a one-cycle write port to the character RAM, the user-pattern RAM or the icon RAM.

The address pointer follows the character RAM map of the selected font mode. In two-line mode there is a gap between line one (0x00..0x27) and line two (0x40..0x67). A function-set bit switches between two instruction tables, and display scrolling can be tied to character writes. Each accepted write raises a busy flag for a fixed number of cycles. A clear takes longer, because during that time it fills the whole character RAM with the blank code. Writes that arrive while busy is high are dropped and reported.

The control is a three-state machine. ST_IDLE accepts a write. ST_EXEC counts down the busy time. ST_CLEAR sweeps the character RAM. The transitions are: ST_IDLE to ST_EXEC on any accepted write except clear; ST_IDLE to ST_CLEAR on an accepted clear; ST_CLEAR to ST_EXEC after the sweep writes address 127; ST_EXEC to ST_IDLE when its counter reaches zero.

Top module: `chardisp_ctrl`

## Requirements
- R1: After reset: busy, overrun and ram_we are 0; addr_cnt and shift_ofs are 0; the target is character RAM (ram_tgt code 0); entry_inc and bus8 are 1; every other flag and every extended register is 0.
- R2: An accepted write keeps busy high for exactly CMD_CYCLES cycles. A write presented while busy is high changes no state and produces no RAM write; overrun pulses high for one cycle in the cycle after that write.
- R3: Instruction 0x01 (clear) writes 0x20 to character RAM addresses 0..127, one per cycle, starting in the cycle after acceptance. It sets addr_cnt=0, shift_ofs=0 and entry_inc=1, and it holds busy high for CLEAR_CYCLES cycles in total.
- R4: Instruction 0000001x (home) sets addr_cnt=0 and shift_ofs=0, selects character RAM and writes no RAM.
- R5: A data write (rs=1) pulses ram_we for one cycle, in the cycle after acceptance. ram_addr carries the pointer value from before the write and ram_tgt the current target (0 character, 1 pattern, 2 icon). The pointer then steps +1 if entry_inc=1 and -1 if entry_inc=0.
- R6: In two-line mode the character RAM pointer steps 0x27 to 0x40 and 0x67 to 0x00 upward, and 0x40 to 0x27 and 0x00 to 0x67 downward.
- R7: In one-line mode the pointer wraps between 0x4F and 0x00. With double height (N=0, DH=1) it wraps between 0x27 and 0x00.
- R8: Instruction 000001 I S sets entry_inc=I and entry_shift=S. With S=1, each character RAM data write moves shift_ofs +1 when I=1 and -1 when I=0, modulo the line length (40 in two-line or double-height mode, 80 otherwise). Pattern and icon writes never move shift_ofs.
- R9: In the normal table, 0001 SC RL xx moves the pointer one step (right when RL=1) if SC=0. If SC=1 it moves shift_ofs (+1 for left, RL=0; -1 for right, RL=1) and leaves the pointer unchanged.
- R10: Function set 001 DL N DH x IS loads bus8=DL and ext_table=IS. N and DH are loaded only if they are not both 1; a change of either clears shift_ofs.
- R11: Instruction 00001 D C B loads disp_on, cursor_on and blink_on.
- R12: In the normal table, 01aaaaaa selects pattern RAM with pointer aaaaaa (the pointer wraps modulo 64). In both tables, 1aaaaaaa selects character RAM with pointer aaaaaaa.
- R13: In the extended table, 0100aaaa selects icon RAM (the pointer wraps modulo 16). 0001 B F2 F1 F0 loads bias_sel and osc_adj, 0101 I O C5 C4 loads icon_on, booster_on and contrast[5:4], 0110 F R2 R1 R0 loads follower_on and amp_ratio, and 0111 C3..C0 loads contrast[3:0]. None of these codes acts as a shift or a pattern address.
- R14: In the normal table the extended codes have no extended effect: 0101xxxx is a pattern address set and leaves the extended registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe, one byte per cycle |
| wr_rs | input | 1 | 1 = data byte, 0 = instruction |
| wr_data | input | 8 | Written byte |
| busy | output | 1 | Operation in progress; writes are dropped |
| overrun | output | 1 | One-cycle pulse for each dropped write |
| ram_we | output | 1 | RAM write enable |
| ram_tgt | output | 2 | RAM select: 0 character, 1 pattern, 2 icon |
| ram_addr | output | 7 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| addr_cnt | output | 7 | Address pointer |
| shift_ofs | output | 7 | Display window offset |
| entry_inc | output | 1 | Pointer steps up |
| entry_shift | output | 1 | Writes scroll the display |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| two_line | output | 1 | Two-line mode |
| dbl_height | output | 1 | Double-height font |
| ext_table | output | 1 | Extended instruction table selected |
| bus8 | output | 1 | 8-bit host bus width flag |
| bias_sel | output | 1 | Bias select register |
| osc_adj | output | 3 | Oscillator adjust register |
| icon_on | output | 1 | Icon display enable |
| booster_on | output | 1 | Booster enable register |
| follower_on | output | 1 | Follower enable register |
| amp_ratio | output | 3 | Amplifier ratio register |
| contrast | output | 6 | Contrast register |

## Verification
On every cycle the embedded properties check four things: the clear sweep writes only the blank code to character RAM; pointer and offset hold still while busy; a pointer inside the active map stays inside it after a character write; and the forbidden two-line double-height combination never appears, with the offset always below the line length. Which table decodes a given byte, the exact wrap points of each font mode, the busy duration, and whether a dropped write really left no trace can only be shown by the scenarios. For these, the bench's behavioural model follows every output cycle by cycle.

// File: rtl/cdu_pkg.sv
package cdu_pkg;

    typedef enum logic [1:0] {
        TGT_DD   = 2'd0,
        TGT_CG   = 2'd1,
        TGT_ICON = 2'd2
    } tgt_e;

    typedef enum logic [3:0] {
        OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP, OP_SHIFT, OP_FUNC,
        OP_CGADDR, OP_DDADDR, OP_OSC, OP_ICONADDR, OP_PWR, OP_FOLLOW, OP_CONTRAST
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EXEC  = 2'd1,
        ST_CLEAR = 2'd2
    } st_e;

    localparam logic [6:0] LINE1_LAST = 7'h27;
    localparam logic [6:0] LINE2_FIRST = 7'h40;
    localparam logic [6:0] LINE2_LAST = 7'h67;
    localparam logic [6:0] SINGLE_LAST = 7'h4F;
    localparam logic [7:0] BLANK_CODE = 8'h20;

    function automatic logic [6:0] ofs_step(input logic [6:0] ofs, input logic left,
                                            input logic [6:0] len);
        if (left)
            return (ofs == len - 7'd1) ? 7'd0 : ofs + 7'd1;
        else
            return (ofs == 7'd0) ? len - 7'd1 : ofs - 7'd1;
    endfunction

endpackage

// File: rtl/cdu_decode.sv
module cdu_decode
    import cdu_pkg::*;
(
    input  logic [7:0] code,
    input  logic       ext_sel,
    output op_e        op
);
    always_comb begin
        if (code[7])
            op = OP_DDADDR;
        else if (code[6]) begin
            if (!ext_sel)
                op = OP_CGADDR;
            else begin
                unique case (code[5:4])
                    2'b00:   op = OP_ICONADDR;
                    2'b01:   op = OP_PWR;
                    2'b10:   op = OP_FOLLOW;
                    default: op = OP_CONTRAST;
                endcase
            end
        end
        else if (code[5])
            op = OP_FUNC;
        else if (code[4])
            op = ext_sel ? OP_OSC : OP_SHIFT;
        else if (code[3])
            op = OP_DISP;
        else if (code[2])
            op = OP_ENTRY;
        else if (code[1])
            op = OP_HOME;
        else if (code[0])
            op = OP_CLEAR;
        else
            op = OP_NONE;
    end
endmodule

// File: rtl/cdu_addr_step.sv
module cdu_addr_step
    import cdu_pkg::*;
(
    input  logic [6:0] cur,
    input  tgt_e       tgt,
    input  logic       up,
    input  logic       dual,
    input  logic       tall,
    output logic [6:0] nxt
);
    logic [6:0] wrap_last;

    always_comb begin
        wrap_last = tall ? LINE1_LAST : SINGLE_LAST;
        unique case (tgt)
            TGT_CG:   nxt = {1'b0, up ? cur[5:0] + 6'd1 : cur[5:0] - 6'd1};
            TGT_ICON: nxt = {3'b000, up ? cur[3:0] + 4'd1 : cur[3:0] - 4'd1};
            default: begin
                if (dual) begin
                    if (up)
                        nxt = (cur == LINE1_LAST) ? LINE2_FIRST :
                              (cur == LINE2_LAST) ? 7'd0 : cur + 7'd1;
                    else
                        nxt = (cur == 7'd0) ? LINE2_LAST :
                              (cur == LINE2_FIRST) ? LINE1_LAST : cur - 7'd1;
                end else begin
                    if (up)
                        nxt = (cur == wrap_last) ? 7'd0 : cur + 7'd1;
                    else
                        nxt = (cur == 7'd0) ? wrap_last : cur - 7'd1;
                end
            end
        endcase
    end
endmodule

// File: rtl/chardisp_ctrl.sv
module chardisp_ctrl
    import cdu_pkg::*;
#(
    parameter int CMD_CYCLES   = 4,
    parameter int CLEAR_CYCLES = 140
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  logic       wr_rs,
    input  logic [7:0] wr_data,
    output logic       busy,
    output logic       overrun,
    output logic       ram_we,
    output logic [1:0] ram_tgt,
    output logic [6:0] ram_addr,
    output logic [7:0] ram_wdata,
    output logic [6:0] addr_cnt,
    output logic [6:0] shift_ofs,
    output logic       entry_inc,
    output logic       entry_shift,
    output logic       disp_on,
    output logic       cursor_on,
    output logic       blink_on,
    output logic       two_line,
    output logic       dbl_height,
    output logic       ext_table,
    output logic       bus8,
    output logic       bias_sel,
    output logic [2:0] osc_adj,
    output logic       icon_on,
    output logic       booster_on,
    output logic       follower_on,
    output logic [2:0] amp_ratio,
    output logic [5:0] contrast
);
    localparam int SWEEP_LEN = 128;
    localparam int CNT_W = $clog2(CLEAR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CMD_LOAD = CNT_W'(CMD_CYCLES - 1);
    localparam logic [CNT_W-1:0] TAIL_LOAD = CNT_W'(CLEAR_CYCLES - SWEEP_LEN - 1);
    localparam logic [6:0] SWEEP_LAST = 7'(SWEEP_LEN - 1);

    st_e             state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    tgt_e            tgt_q;
    op_e             op;
    logic            accept;
    logic [6:0]      step_nxt;
    logic            step_up;
    logic [6:0]      line_len;

    assign accept   = wr_valid && (state_q == ST_IDLE);
    assign busy     = (state_q != ST_IDLE);
    assign line_len = (two_line || dbl_height) ? 7'd40 : 7'd80;
    assign step_up  = wr_rs ? entry_inc : wr_data[2];

    cdu_decode u_dec (
        .code    (wr_data),
        .ext_sel (ext_table),
        .op      (op)
    );

    cdu_addr_step u_step (
        .cur  (addr_cnt),
        .tgt  (tgt_q),
        .up   (step_up),
        .dual (two_line),
        .tall (dbl_height),
        .nxt  (step_nxt)
    );

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!wr_rs && op == OP_CLEAR)
                        state_d = ST_CLEAR;
                    else begin
                        state_d = ST_EXEC;
                        cnt_d   = CMD_LOAD;
                    end
                end
            end
            ST_CLEAR: begin
                if (ram_addr == SWEEP_LAST) begin
                    state_d = ST_EXEC;
                    cnt_d   = TAIL_LOAD;
                end
            end
            ST_EXEC: begin
                if (cnt_q == '0)
                    state_d = ST_IDLE;
                else
                    cnt_d = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun     <= 1'b0;
            ram_we      <= 1'b0;
            ram_tgt     <= TGT_DD;
            ram_addr    <= '0;
            ram_wdata   <= '0;
            addr_cnt    <= '0;
            shift_ofs   <= '0;
            tgt_q       <= TGT_DD;
            entry_inc   <= 1'b1;
            entry_shift <= 1'b0;
            disp_on     <= 1'b0;
            cursor_on   <= 1'b0;
            blink_on    <= 1'b0;
            two_line    <= 1'b0;
            dbl_height  <= 1'b0;
            ext_table   <= 1'b0;
            bus8        <= 1'b1;
            bias_sel    <= 1'b0;
            osc_adj     <= '0;
            icon_on     <= 1'b0;
            booster_on  <= 1'b0;
            follower_on <= 1'b0;
            amp_ratio   <= '0;
            contrast    <= '0;
        end else begin
            overrun <= wr_valid && (state_q != ST_IDLE);
            ram_we  <= 1'b0;
            if (state_q == ST_CLEAR && ram_addr != SWEEP_LAST) begin
                ram_we    <= 1'b1;
                ram_addr  <= ram_addr + 7'd1;
                ram_wdata <= BLANK_CODE;
                ram_tgt   <= TGT_DD;
            end
            if (accept) begin
                if (wr_rs) begin
                    ram_we    <= 1'b1;
                    ram_tgt   <= tgt_q;
                    ram_addr  <= addr_cnt;
                    ram_wdata <= wr_data;
                    addr_cnt  <= step_nxt;
                    if (tgt_q == TGT_DD && entry_shift)
                        shift_ofs <= ofs_step(shift_ofs, entry_inc, line_len);
                end else begin
                    unique case (op)
                        OP_CLEAR: begin
                            addr_cnt  <= '0;
                            shift_ofs <= '0;
                            entry_inc <= 1'b1;
                            tgt_q     <= TGT_DD;
                            ram_we    <= 1'b1;
                            ram_tgt   <= TGT_DD;
                            ram_addr  <= '0;
                            ram_wdata <= BLANK_CODE;
                        end
                        OP_HOME: begin
                            addr_cnt  <= '0;
                            shift_ofs <= '0;
                            tgt_q     <= TGT_DD;
                        end
                        OP_ENTRY: begin
                            entry_inc   <= wr_data[1];
                            entry_shift <= wr_data[0];
                        end
                        OP_DISP: begin
                            disp_on   <= wr_data[2];
                            cursor_on <= wr_data[1];
                            blink_on  <= wr_data[0];
                        end
                        OP_SHIFT: begin
                            if (wr_data[3])
                                shift_ofs <= ofs_step(shift_ofs, !wr_data[2], line_len);
                            else
                                addr_cnt <= step_nxt;
                        end
                        OP_FUNC: begin
                            bus8      <= wr_data[4];
                            ext_table <= wr_data[0];
                            if (!(wr_data[3] && wr_data[2])) begin
                                two_line   <= wr_data[3];
                                dbl_height <= wr_data[2];
                                if (wr_data[3] != two_line || wr_data[2] != dbl_height)
                                    shift_ofs <= '0;
                            end
                        end
                        OP_CGADDR: begin
                            addr_cnt <= {1'b0, wr_data[5:0]};
                            tgt_q    <= TGT_CG;
                        end
                        OP_DDADDR: begin
                            addr_cnt <= wr_data[6:0];
                            tgt_q    <= TGT_DD;
                        end
                        OP_ICONADDR: begin
                            addr_cnt <= {3'b000, wr_data[3:0]};
                            tgt_q    <= TGT_ICON;
                        end
                        OP_OSC: begin
                            bias_sel <= wr_data[3];
                            osc_adj  <= wr_data[2:0];
                        end
                        OP_PWR: begin
                            icon_on       <= wr_data[3];
                            booster_on    <= wr_data[2];
                            contrast[5:4] <= wr_data[1:0];
                        end
                        OP_FOLLOW: begin
                            follower_on <= wr_data[3];
                            amp_ratio   <= wr_data[2:0];
                        end
                        OP_CONTRAST: contrast[3:0] <= wr_data[3:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    function automatic logic in_map(input logic [6:0] a, input logic dual, input logic tall);
        if (dual)
            return (a <= LINE1_LAST) || (a >= LINE2_FIRST && a <= LINE2_LAST);
        else if (tall)
            return a <= LINE1_LAST;
        else
            return a <= SINGLE_LAST;
    endfunction

    // R3
    clear_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR) |-> (ram_we && ram_wdata == BLANK_CODE && ram_tgt == TGT_DD));

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(addr_cnt) && $stable(shift_ofs)));

    // R6
    map_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_tgt == TGT_DD && state_q != ST_CLEAR &&
         in_map(ram_addr, two_line, dbl_height)) |-> in_map(addr_cnt, two_line, dbl_height));

    // R8
    pattern_noshift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_tgt != TGT_DD) |-> (shift_ofs == $past(shift_ofs)));

    // R8
    ofs_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_ofs < line_len);

    // R10
    no_forbidden_font_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(two_line && dbl_height));

endmodule

// File: tb/tb_chardisp_ctrl.sv
`timescale 1ns/1ps
module tb_chardisp_ctrl;
    localparam int CMD = 4;
    localparam int CLR = 140;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic wr_rs = 1'b0;
    logic [7:0] wr_data = '0;
    logic busy, overrun, ram_we;
    logic [1:0] ram_tgt;
    logic [6:0] ram_addr, addr_cnt, shift_ofs;
    logic [7:0] ram_wdata;
    logic entry_inc, entry_shift, disp_on, cursor_on, blink_on;
    logic two_line, dbl_height, ext_table, bus8;
    logic bias_sel, icon_on, booster_on, follower_on;
    logic [2:0] osc_adj, amp_ratio;
    logic [5:0] contrast;

    always #2.5 clk = ~clk;

    chardisp_ctrl #(.CMD_CYCLES(CMD), .CLEAR_CYCLES(CLR)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_rs(wr_rs), .wr_data(wr_data),
        .busy(busy), .overrun(overrun), .ram_we(ram_we), .ram_tgt(ram_tgt),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .addr_cnt(addr_cnt),
        .shift_ofs(shift_ofs), .entry_inc(entry_inc), .entry_shift(entry_shift),
        .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on),
        .two_line(two_line), .dbl_height(dbl_height), .ext_table(ext_table), .bus8(bus8),
        .bias_sel(bias_sel), .osc_adj(osc_adj), .icon_on(icon_on), .booster_on(booster_on),
        .follower_on(follower_on), .amp_ratio(amp_ratio), .contrast(contrast)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic expect_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // behavioural reference model
    int m_busy, m_sweep, m_ac, m_tgt, m_ofs;
    bit m_id, m_s, m_d, m_c, m_b, m_n, m_dh, m_is, m_dl;
    int m_bias, m_osc, m_ion, m_bon, m_fon, m_amp, m_con;
    bit e_we, e_ovr;
    int e_tgt, e_addr, e_wd;

    function automatic int m_len();
        return (m_n || m_dh) ? 40 : 80;
    endfunction

    function automatic int m_step(int a, int tgt, bit up);
        int idx, span;
        if (tgt == 1) return (a + (up ? 1 : 63)) % 64;
        if (tgt == 2) return (a + (up ? 1 : 15)) % 16;
        if (m_n) begin
            idx = (a >= 64) ? 40 + (a - 64) : a;
            idx = (idx + (up ? 1 : 79)) % 80;
            return (idx / 40) * 64 + (idx % 40);
        end
        span = m_dh ? 40 : 80;
        return (a + (up ? 1 : span - 1)) % span;
    endfunction

    function automatic int m_shift(int o, bit left);
        return left ? (o + 1) % m_len() : (o + m_len() - 1) % m_len();
    endfunction

    always @(posedge clk) begin
        bit acc;
        int d;
        if (!rst_n) begin
            m_busy = 0; m_sweep = -1; m_ac = 0; m_tgt = 0; m_ofs = 0;
            m_id = 1; m_s = 0; m_d = 0; m_c = 0; m_b = 0; m_n = 0; m_dh = 0; m_is = 0; m_dl = 1;
            m_bias = 0; m_osc = 0; m_ion = 0; m_bon = 0; m_fon = 0; m_amp = 0; m_con = 0;
            e_we = 0; e_ovr = 0; e_tgt = 0; e_addr = 0; e_wd = 0;
        end else begin
            e_we = 0;
            if (m_sweep >= 0) begin
                m_sweep++;
                if (m_sweep < 128) begin
                    e_we = 1; e_tgt = 0; e_addr = m_sweep; e_wd = 32;
                end else m_sweep = -1;
            end
            acc = wr_valid && m_busy == 0;
            e_ovr = wr_valid && m_busy != 0;
            if (m_busy > 0) m_busy--;
            d = int'(wr_data);
            if (acc) begin
                m_busy = CMD;
                if (wr_rs) begin
                    e_we = 1; e_tgt = m_tgt; e_addr = m_ac; e_wd = d;
                    if (m_tgt == 0 && m_s) m_ofs = m_shift(m_ofs, m_id);
                    m_ac = m_step(m_ac, m_tgt, m_id);
                end else if (d >= 128) begin
                    m_ac = d - 128; m_tgt = 0;
                end else if (d >= 64) begin
                    if (!m_is) begin m_ac = d % 64; m_tgt = 1; end
                    else if (d < 80) begin m_ac = d % 16; m_tgt = 2; end
                    else if (d < 96) begin m_ion = (d >> 3) & 1; m_bon = (d >> 2) & 1; m_con = (m_con % 16) + (d % 4) * 16; end
                    else if (d < 112) begin m_fon = (d >> 3) & 1; m_amp = d % 8; end
                    else m_con = (m_con / 16) * 16 + d % 16;
                end else if (d >= 32) begin
                    m_dl = d[4]; m_is = d[0];
                    if (!(d[3] && d[2])) begin
                        if (m_n != d[3] || m_dh != d[2]) m_ofs = 0;
                        m_n = d[3]; m_dh = d[2];
                    end
                end else if (d >= 16) begin
                    if (m_is) begin m_bias = (d >> 3) & 1; m_osc = d % 8; end
                    else if (d[3]) m_ofs = m_shift(m_ofs, !d[2]);
                    else m_ac = m_step(m_ac, m_tgt, d[2]);
                end else if (d >= 8) begin
                    m_d = d[2]; m_c = d[1]; m_b = d[0];
                end else if (d >= 4) begin
                    m_id = d[1]; m_s = d[0];
                end else if (d >= 2) begin
                    m_ac = 0; m_ofs = 0; m_tgt = 0;
                end else if (d == 1) begin
                    m_ac = 0; m_ofs = 0; m_id = 1; m_tgt = 0; m_busy = CLR; m_sweep = 0;
                    e_we = 1; e_tgt = 0; e_addr = 0; e_wd = 32;
                end
            end
        end
    end

    int sweep_cnt = 0;
    int ovr_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == (m_busy != 0), "R2 busy", busy, m_busy != 0);
            chk(overrun == e_ovr, "R2 overrun", overrun, e_ovr);
            chk(ram_we == e_we, "R5 ram_we", ram_we, e_we);
            if (e_we) begin
                chk(int'(ram_addr) == e_addr, "R5 ram_addr", ram_addr, e_addr);
                chk(int'(ram_tgt) == e_tgt, "R5 ram_tgt", ram_tgt, e_tgt);
                chk(int'(ram_wdata) == e_wd, "R5 ram_wdata", ram_wdata, e_wd);
            end
            chk(int'(addr_cnt) == m_ac, "R6 addr_cnt", addr_cnt, m_ac);
            chk(int'(shift_ofs) == m_ofs, "R8 shift_ofs", shift_ofs, m_ofs);
            chk({entry_inc, entry_shift, disp_on, cursor_on, blink_on, two_line, dbl_height, ext_table, bus8}
                == {m_id, m_s, m_d, m_c, m_b, m_n, m_dh, m_is, m_dl}, "R10 flags",
                {entry_inc, entry_shift, disp_on, cursor_on, blink_on, two_line, dbl_height, ext_table, bus8},
                {m_id, m_s, m_d, m_c, m_b, m_n, m_dh, m_is, m_dl});
            chk(int'(bias_sel) == m_bias && int'(osc_adj) == m_osc && int'(icon_on) == m_ion &&
                int'(booster_on) == m_bon && int'(follower_on) == m_fon && int'(amp_ratio) == m_amp &&
                int'(contrast) == m_con, "R13 ext regs", contrast, m_con);
            if (ram_we && ram_tgt == 2'd0 && ram_wdata == 8'h20) sweep_cnt++;
            if (overrun) ovr_cnt++;
        end
    end

    int last_busy = 0;

    task automatic send(input bit rs, input logic [7:0] d);
        int n;
        @(negedge clk);
        wr_valid = 1'b1; wr_rs = rs; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        last_busy = n;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_eq("R1 busy", busy, 0);
        expect_eq("R1 addr_cnt", addr_cnt, 0);
        expect_eq("R1 entry_inc", entry_inc, 1);
        expect_eq("R1 bus8", bus8, 1);
        expect_eq("R1 ram_we", ram_we, 0);

        send(0, 8'h38);
        expect_eq("R2 busy length", last_busy, CMD);
        send(0, 8'h0F);
        expect_eq("R11 disp/cursor/blink", {disp_on, cursor_on, blink_on}, 3'b111);

        sweep_cnt = 0;
        send(0, 8'h01);
        expect_eq("R3 blank writes", sweep_cnt, 128);
        expect_eq("R3 busy length", last_busy, CLR);
        expect_eq("R3 addr_cnt", addr_cnt, 0);

        // R6 two-line map
        send(0, 8'hA7); send(1, 8'h41);
        expect_eq("R6 0x27 up", addr_cnt, 7'h40);
        send(0, 8'hE7); send(1, 8'h42);
        expect_eq("R6 0x67 up", addr_cnt, 7'h00);
        send(0, 8'h04); send(0, 8'hC0); send(1, 8'h43);
        expect_eq("R6 0x40 down", addr_cnt, 7'h27);

        // R8 scroll on write, none for pattern RAM
        send(0, 8'h07); send(1, 8'h44);
        expect_eq("R8 scroll", shift_ofs, 1);
        send(0, 8'h48);
        expect_eq("R12 cg addr", addr_cnt, 8);
        send(1, 8'h1F);
        expect_eq("R8 cg no scroll", shift_ofs, 1);
        expect_eq("R12 cg step", addr_cnt, 9);

        // R9 shift instruction
        send(0, 8'h80); send(0, 8'h18);
        expect_eq("R9 display left", shift_ofs, 2);
        send(0, 8'h1C);
        expect_eq("R9 display right", shift_ofs, 1);
        expect_eq("R9 pointer kept", addr_cnt, 0);
        send(0, 8'h14);
        expect_eq("R9 cursor right", addr_cnt, 1);
        send(0, 8'h10); send(0, 8'h10);
        expect_eq("R9 cursor left wrap", addr_cnt, 7'h67);

        send(0, 8'h02);
        expect_eq("R4 home ptr", addr_cnt, 0);
        expect_eq("R4 home ofs", shift_ofs, 0);

        send(0, 8'h3C);
        expect_eq("R10 forbidden", {two_line, dbl_height}, 2'b10);

        // R7 one-line and double height
        send(0, 8'h30); send(0, 8'h06); send(0, 8'hCF); send(1, 8'h45);
        expect_eq("R7 one-line wrap", addr_cnt, 0);
        send(0, 8'h34); send(0, 8'hA7); send(1, 8'h46);
        expect_eq("R7 double-height wrap", addr_cnt, 0);

        // R13 extended table
        send(0, 8'h39); send(0, 8'h4E); send(1, 8'h01); send(1, 8'h02);
        expect_eq("R13 icon wrap", addr_cnt, 0);
        send(0, 8'h5E); send(0, 8'h6D); send(0, 8'h7A); send(0, 8'h1B);
        expect_eq("R13 contrast", contrast, 6'h2A);
        expect_eq("R13 amp", amp_ratio, 5);
        expect_eq("R13 osc no shift", shift_ofs, 0);

        // R14 normal table ignores extended codes
        send(0, 8'h38); send(0, 8'h5E);
        expect_eq("R14 cg addr", addr_cnt, 7'h1E);
        expect_eq("R14 ext kept", {icon_on, contrast}, {1'b1, 6'h2A});

        // R2 dropped write
        ovr_cnt = 0;
        @(negedge clk);
        wr_valid = 1'b1; wr_rs = 1'b1; wr_data = 8'h50;
        @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        while (busy) @(negedge clk);
        expect_eq("R2 overrun count", ovr_cnt, 1);
        expect_eq("R2 one write kept", addr_cnt, 7'h1F);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule